// File: doc/BRIEF.md
# Multi-Channel Servo Pulse Width Capture

This block measures the high time of several independent servo-style pulse inputs at once. Each input passes through its own synchroniser and edge detector. One free-running microsecond timestamp serves every channel. It advances on a tick that a prescaler makes from the system clock. When an input rises, the channel records the timestamp. When the input falls, the channel subtracts the recorded value from the current timestamp. It then latches the result as the pulse width and raises a sticky new-pulse flag for that channel.

The widths are read as bytes through a small read port. Each channel occupies two adjacent byte addresses, high byte first. A consumer holds `rd_active` high for the whole of a multi-byte read. While it is high, the byte image does not change, so the two halves of a width always belong to the same measurement. Filtering and range checking of widths are left to the consumer.

Top module: `rc_pulse_capture`

## Requirements
- R1: The timestamp advances by one every `CLK_PER_US` clock cycles and wraps modulo 2^`TS_W`. A pulse held high for N·`CLK_PER_US` clock cycles therefore measures exactly N.
- R2: A rising edge on a channel stores the current timestamp for that channel only.
- R3: A falling edge latches width = (current timestamp − stored rise timestamp) mod 2^`TS_W`. This also holds for a pulse that spans the timestamp wrap. The latched width changes on no other event.
- R4: Channels are independent. Edges on any number of channels in the same cycle are all handled, each with its own width.
- R5: A measured falling edge sets that channel's `new_pulse` bit. The bit stays set until `flag_clr` for that channel is high in a cycle with no new falling edge. A falling edge in the same cycle as a clear leaves the bit set.
- R6: A falling edge with no rising edge since reset is ignored: width and flag are unchanged. An input that is already high when reset ends does not count as a rising edge.
- R7: Byte address 2k reads bits above bit 7 of channel k's width (width/256). Address 2k+1 reads width mod 256. Addresses at or beyond 2·`NUM_CH` read 0.
- R8: While `rd_active` is high, every readable byte stays constant. When it is low, the byte image follows the latched widths one cycle later.
- R9: After reset, all widths read 0 and all `new_pulse` bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwm_in | input | NUM_CH | Asynchronous pulse inputs, one per channel |
| flag_clr | input | NUM_CH | Per-channel clear of the new-pulse flag |
| new_pulse | output | NUM_CH | Sticky per-channel new-width flag |
| rd_active | input | 1 | High for the duration of a read; freezes the byte image |
| rd_addr | input | ADDR_W | Byte address: 2k high byte, 2k+1 low byte of channel k |
| rd_data | output | 8 | Selected byte of the frozen width image |

## Verification
The bench builds the block with six channels, `CLK_PER_US` = 4, `SYNC_STAGES` = 2 and a narrowed `TS_W` of 10. With a timestamp that wraps every 4096 cycles, two back-to-back 1000 µs pulses make a measurement across the wrap certain within a short run. Widths above 255 still exercise a non-zero high byte. Six channels leave unused byte addresses 12 to 15 to probe the out-of-range reads.

// File: rtl/pwc_pkg.sv
// Package: shared types and constants of the pulse width capture block.
// Assumes: byte-wide register read port, two bytes per channel.
package pwc_pkg;
    typedef logic [7:0] pwc_byte_t;
    localparam int PWC_BYTES_PER_CH = 2;
endpackage

// File: rtl/pwc_timebase.sv
// Module: microsecond timebase.
// Divides the system clock by CLK_PER_US into a one-cycle tick and counts
// ticks in a TS_W-bit timestamp that wraps freely.
// Assumes: CLK_PER_US >= 1.
module pwc_timebase #(
    parameter int CLK_PER_US = 8,
    parameter int TS_W       = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [TS_W-1:0] ts
);
    localparam int DIV_W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_PER_US - 1);

    logic [DIV_W-1:0] div_q;
    logic             tick;

    assign tick = (div_q == DIV_LAST);

    // Prescaler: counts system clocks within one microsecond.
    always_ff @(posedge clk) begin
        if (!rst_n)    div_q <= '0;
        else if (tick) div_q <= '0;
        else           div_q <= div_q + 1'b1;
    end

    // Timestamp: free-running microsecond count, wraps modulo 2^TS_W.
    always_ff @(posedge clk) begin
        if (!rst_n)    ts <= '0;
        else if (tick) ts <= ts + 1'b1;
    end

    AST_TS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (ts == TS_W'($past(ts) + 1'b1))); // R1
    AST_TS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(ts)); // R1
endmodule

// File: rtl/pwc_channel.sv
// Module: one capture channel.
// Synchronises its input, finds edges against the previous sampled level,
// records the timestamp on a rise and latches the modular difference on a
// fall, raising a sticky flag.
// Assumes: edge_en stays low until the synchroniser holds real samples.
module pwc_channel #(
    parameter int TS_W        = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            edge_en,
    input  logic            pin,
    input  logic [TS_W-1:0] ts,
    input  logic            clr,
    output logic [TS_W-1:0] width,
    output logic            flag
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   lvl;
    logic                   prev_q;
    logic                   armed_q;
    logic [TS_W-1:0]        rise_ts_q;
    logic                   rise;
    logic                   fall;
    logic                   fall_ok;

    assign lvl     = sync_q[SYNC_STAGES-1];
    assign rise    = edge_en &  lvl & ~prev_q;
    assign fall    = edge_en & ~lvl &  prev_q;
    assign fall_ok = fall & armed_q;

    // Synchroniser: shifts the asynchronous pin into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
    end

    // Previous level: reference for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl;
    end

    // Rise capture: stores the timestamp and arms the channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_ts_q <= '0;
            armed_q   <= 1'b0;
        end else if (rise) begin
            rise_ts_q <= ts;
            armed_q   <= 1'b1;
        end else if (fall) begin
            armed_q   <= 1'b0;
        end
    end

    // Width latch: modular difference on an armed falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n)       width <= '0;
        else if (fall_ok) width <= ts - rise_ts_q;
    end

    // New-pulse flag: set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag <= 1'b0;
        else if (fall_ok) flag <= 1'b1;
        else if (clr)     flag <= 1'b0;
    end

    AST_FLAG_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        fall_ok |=> flag); // R5
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag); // R5
    AST_WIDTH_ONLY_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !fall |=> $stable(width)); // R3
    AST_UNARMED_FALL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (fall && !armed_q) |=> ($stable(width) && ($past(flag) == flag || $past(clr)))); // R6
endmodule

// File: rtl/pwc_byte_bank.sv
// Module: coherent byte image of all widths.
// Copies the live widths into a snapshot whenever no read is open, and
// serves bytes from the snapshot: high byte at even, low byte at odd address.
// Assumes: 8 < TS_W <= 16 and NUM_CH >= 2.
module pwc_byte_bank
    import pwc_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int TS_W   = 16,
    parameter int ADDR_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd_active,
    input  logic [TS_W-1:0] width [NUM_CH],
    input  logic [ADDR_W-1:0] rd_addr,
    output pwc_byte_t       rd_data
);
    localparam int NUM_BYTES = NUM_CH * PWC_BYTES_PER_CH;
    localparam int CH_W      = ADDR_W - 1;

    logic [TS_W-1:0] snap_q [NUM_CH];
    logic [CH_W-1:0] sel_ch;

    assign sel_ch = rd_addr[ADDR_W-1:1];

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_snap
            // Snapshot register: frozen while a read is open.
            always_ff @(posedge clk) begin
                if (!rst_n)          snap_q[g] <= '0;
                else if (!rd_active) snap_q[g] <= width[g];
            end

            AST_SNAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
                rd_active |=> $stable(snap_q[g])); // R8
        end
    endgenerate

    // Byte select: picks the half of the addressed channel's snapshot.
    always_comb begin
        rd_data = '0;
        if (int'(rd_addr) < NUM_BYTES) begin
            if (rd_addr[0]) rd_data = snap_q[sel_ch][7:0];
            else            rd_data = pwc_byte_t'(snap_q[sel_ch] >> 8);
        end
    end
endmodule

// File: rtl/rc_pulse_capture.sv
// Module: multi-channel servo pulse width capture (top).
// Shares one microsecond timestamp across NUM_CH capture channels and
// exports the widths as a coherent byte image.
// Assumes: 8 < TS_W <= 16, NUM_CH >= 2, SYNC_STAGES >= 2.
module rc_pulse_capture
    import pwc_pkg::*;
#(
    parameter int NUM_CH      = 6,
    parameter int CLK_PER_US  = 8,
    parameter int TS_W        = 16,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = $clog2(NUM_CH * PWC_BYTES_PER_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] pwm_in,
    input  logic [NUM_CH-1:0] flag_clr,
    output logic [NUM_CH-1:0] new_pulse,
    input  logic              rd_active,
    input  logic [ADDR_W-1:0] rd_addr,
    output pwc_byte_t         rd_data
);
    localparam int WARM_W = SYNC_STAGES + 1;

    logic [TS_W-1:0]   ts;
    logic [TS_W-1:0]   width [NUM_CH];
    logic [WARM_W-1:0] warm_q;
    logic              edge_en;

    assign edge_en = warm_q[WARM_W-1];

    // Warm-up: holds edge detection off until the synchronisers are filled.
    always_ff @(posedge clk) begin
        if (!rst_n) warm_q <= '0;
        else        warm_q <= {warm_q[WARM_W-2:0], 1'b1};
    end

    pwc_timebase #(
        .CLK_PER_US (CLK_PER_US),
        .TS_W       (TS_W)
    ) u_timebase (
        .clk   (clk),
        .rst_n (rst_n),
        .ts    (ts)
    );

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
            pwc_channel #(
                .TS_W        (TS_W),
                .SYNC_STAGES (SYNC_STAGES)
            ) u_channel (
                .clk     (clk),
                .rst_n   (rst_n),
                .edge_en (edge_en),
                .pin     (pwm_in[g]),
                .ts      (ts),
                .clr     (flag_clr[g]),
                .width   (width[g]),
                .flag    (new_pulse[g])
            );
        end
    endgenerate

    pwc_byte_bank #(
        .NUM_CH (NUM_CH),
        .TS_W   (TS_W),
        .ADDR_W (ADDR_W)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_active (rd_active),
        .width     (width),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data)
    );

    AST_RESET_FLAGS_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (new_pulse == '0)); // R9
endmodule

// File: tb/rc_pulse_capture_bench.sv
module rc_pulse_capture_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NCH  = 6;
    localparam int P    = 4;
    localparam int TSW  = 10;
    localparam int AW   = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] pwm_in = '0;
    logic [NCH-1:0] flag_clr = '0;
    logic [NCH-1:0] new_pulse;
    logic           rd_active = 1'b0;
    logic [AW-1:0]  rd_addr = '0;
    logic [7:0]     rd_data;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rc_pulse_capture #(
        .NUM_CH (NCH), .CLK_PER_US (P), .TS_W (TSW), .SYNC_STAGES (2)
    ) u_rc_pulse_capture (
        .clk (clk), .rst_n (rst_n), .pwm_in (pwm_in), .flag_clr (flag_clr),
        .new_pulse (new_pulse), .rd_active (rd_active), .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic read_byte(input int addr, output int v);
        rd_addr = AW'(addr);
        #1;
        v = int'(rd_data);
    endtask

    task automatic read_width(input int ch, output int v);
        int hi, lo;
        read_byte(2*ch, hi);
        read_byte(2*ch+1, lo);
        v = hi*256 + lo;
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    // Raises all masked channels together, drops each after w[ch] microseconds.
    task automatic pulses(input logic [NCH-1:0] mask, input int w0, input int w1,
                          input int w2, input int w3, input int w4, input int w5);
        int w [NCH];
        int mx;
        w[0]=w0; w[1]=w1; w[2]=w2; w[3]=w3; w[4]=w4; w[5]=w5;
        mx = 0;
        for (int c = 0; c < NCH; c++) if (mask[c] && w[c] > mx) mx = w[c];
        @(negedge clk);
        pwm_in = pwm_in | mask;
        for (int t = 1; t <= mx; t++) begin
            repeat (P) @(negedge clk);
            for (int c = 0; c < NCH; c++)
                if (mask[c] && w[c] == t) pwm_in[c] = 1'b0;
        end
        settle();
    endtask

    task automatic t_reset();
        int v;
        check("R9 flags after reset", int'(new_pulse), 0);
        for (int c = 0; c < NCH; c++) begin
            read_width(c, v);
            check("R9 width after reset", v, 0);
        end
    endtask

    task automatic t_ignored_fall();
        int v;
        // channel 0 was high across reset: its fall must be ignored (R6)
        @(negedge clk);
        pwm_in[0] = 1'b0;
        settle();
        check("R6 flag after unarmed fall", int'(new_pulse[0]), 0);
        read_width(0, v);
        check("R6 width after unarmed fall", v, 0);
    endtask

    task automatic t_single();
        int v;
        pulses(6'b000010, 0, 37, 0, 0, 0, 0);
        read_width(1, v);
        check("R2 R3 single width", v, 37);
        check("R5 flag set on ch1", int'(new_pulse), 6'b000010);
        read_byte(3, v);
        check("R7 low byte ch1", v, 37);
    endtask

    task automatic t_flags();
        flag_clr = 6'b000010;
        @(negedge clk);
        flag_clr = '0;
        check("R5 flag cleared", int'(new_pulse[1]), 0);
        // clear held across the fall detection cycle: set must win
        @(negedge clk);
        pwm_in[2] = 1'b1;
        repeat (5*P) @(negedge clk);
        pwm_in[2] = 1'b0;
        flag_clr[2] = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        flag_clr[2] = 1'b0;
        check("R5 set wins over clear", int'(new_pulse[2]), 1);
        repeat (3) @(negedge clk);
        check("R5 flag sticky", int'(new_pulse[2]), 1);
    endtask

    task automatic t_simultaneous();
        int v;
        flag_clr = '1;
        @(negedge clk);
        flag_clr = '0;
        pulses(6'b111001, 12, 0, 0, 50, 300, 7);
        read_width(0, v); check("R4 ch0 width", v, 12);
        read_width(3, v); check("R4 ch3 width", v, 50);
        read_width(4, v); check("R4 ch4 width", v, 300);
        read_width(5, v); check("R4 ch5 width", v, 7);
        read_width(1, v); check("R4 ch1 untouched", v, 37);
        read_byte(8, v);  check("R7 high byte ch4", v, 1);
        read_byte(9, v);  check("R7 low byte ch4", v, 44);
        check("R4 R5 flags", int'(new_pulse), 6'b111001);
    endtask

    task automatic t_coherent();
        int v;
        @(negedge clk);
        rd_active = 1'b1;
        pulses(6'b001000, 0, 0, 0, 20, 0, 0);
        read_width(3, v);
        check("R8 frozen during read", v, 50);
        @(negedge clk);
        rd_active = 1'b0;
        repeat (2) @(negedge clk);
        read_width(3, v);
        check("R8 refreshed after read", v, 20);
    endtask

    task automatic t_wrap();
        int v;
        // two back-to-back 1000 us pulses: the second must span the wrap
        pulses(6'b010000, 0, 0, 0, 0, 1000, 0);
        read_width(4, v);
        check("R1 R3 long width a", v, 1000);
        pulses(6'b010000, 0, 0, 0, 0, 1000, 0);
        read_width(4, v);
        check("R1 R3 width across wrap", v, 1000);
        pulses(6'b010000, 0, 0, 0, 0, 3, 0);
        read_width(4, v);
        check("R1 short width", v, 3);
    endtask

    task automatic t_out_of_range();
        int v;
        for (int a = 2*NCH; a < 16; a++) begin
            read_byte(a, v);
            check("R7 out-of-range address", v, 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        pwm_in[0] = 1'b1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_ignored_fall();
        t_single();
        t_flags();
        t_simultaneous();
        t_coherent();
        t_wrap();
        t_out_of_range();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule